// File: doc/BRIEF.md
# ADC Interrupt Flag Aggregator

This block gathers the status and interrupt flags of a twelve-channel analog-to-digital converter that runs two conversion sequences, A and B. The conversion engine sends it single-cycle pulses: threshold events, per-channel overruns, per-sequence data-valid, per-sequence overrun and per-sequence completion. The block holds these pulses as flags and presents them as one 32-bit status word. Software clears some flags by writing ones to the word. Other flags clear as a side effect of reading the channel result registers or the sequence global data registers, which the surrounding logic signals with read strobes.

Each sequence has one interrupt/DMA trigger flag, and its meaning depends on that sequence's mode bit. In per-conversion mode the flag is the data-valid indication, which a global-data read clears. In end-of-sequence mode the flag is sticky: it is set by sequence completion and cleared by a write of one. Two summary flags combine the threshold flags and the overrun flags. Each sequence flag and each summary flag is gated by an enable input to drive its own interrupt line.

Top module: `adc_irq_flags`

## Requirements
- R1: After reset every status bit reads 0 and all four interrupt outputs are low. Bits 26 and 27 read 0 at all times.
- R2: A pulse on threshold event input i (i = 0..11) sets status bit i on the next clock edge.
- R3: Writing 1 to status bit i (0..11) clears that bit on the next edge. Writing 0 leaves it unchanged. If a write-one and an event hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 12+i shows the overrun of channel i. It is set by the channel overrun pulse and cleared by the channel result read strobe. If both arrive together the set wins. Register writes do not change it.
- R5: Status bit 24 (sequence A) and bit 25 (sequence B) show the sequence global overrun. Each is set by its sequence overrun pulse and cleared by that sequence's global-data read strobe, with the set winning over the read. Writes do not change these bits.
- R6: With a sequence's mode bit at 0, its flag (bit 28 for A, bit 29 for B) shows its data-valid state. Data-valid is set by the data-valid pulse and cleared by the global-data read, with the set winning. Writes do not change the visible flag.
- R7: With a sequence's mode bit at 1, its flag is set by a completion pulse that arrives while the mode is 1. It stays set through global-data reads until a write of 1 to that bit, and a simultaneous completion wins over the write.
- R8: Bit 30 is 1 exactly when any of bits 0..11 is 1.
- R9: Bit 31 is 1 exactly when any per-channel overrun bit is 1, or when a sequence overrun bit is 1 while that sequence's mode bit is 0.
- R10: The interrupt output bits are, in order [0] sequence A flag, [1] sequence B flag, [2] bit 30 and [3] bit 31, each ANDed with the enable input of the same index. The enables have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_evt_i | input | 12 | Enabled threshold event pulses, one per channel |
| ch_ovr_set_i | input | 12 | Per-channel overrun pulses |
| ch_rd_i | input | 12 | Per-channel result register read strobes |
| seq_dv_set_i | input | 2 | Data-valid pulse per sequence ([0] A, [1] B) |
| seq_ovr_set_i | input | 2 | Sequence global overrun pulses |
| seq_done_i | input | 2 | Sequence completion pulses |
| seq_gdat_rd_i | input | 2 | Sequence global data register read strobes |
| seq_mode_i | input | 2 | Mode per sequence: 0 per conversion, 1 end of sequence |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data; a 1 requests a clear |
| irq_en_i | input | 4 | Interrupt enables, same order as irq_o |
| rd_data_o | output | 32 | Status word |
| irq_o | output | 4 | Gated interrupt lines |

## Verification
The bench runs several stimulus patterns. Threshold-only traffic with dense clear writes separates write-one from write-zero behaviour and exposes whether an event is lost when it collides with a clear. Overrun traffic mixed with read strobes and stray writes to bits 12..25 shows whether those bits respond to the correct clearing source only. Sequence traffic in each mode, and then with the mode bits toggling, distinguishes the data-valid path from the sticky path and shows the mode-dependent overrun summary. Random enable patterns show that gating acts only on the interrupt lines.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int REG_W        = 32;
  localparam int SEQ_N        = 2;
  localparam int IRQ_N        = 4;
  localparam int SEQ_FLAG_LSB = 28;
  localparam int THR_SUM_BIT  = 30;
  localparam int OVR_SUM_BIT  = 31;
  localparam int IRQ_SEQA     = 0;
  localparam int IRQ_SEQB     = 1;
  localparam int IRQ_THR      = 2;
  localparam int IRQ_OVR      = 3;

  // A sequence overrun feeds the overrun summary only in per-conversion mode
  function automatic logic [SEQ_N-1:0] seq_ovr_contrib(input logic [SEQ_N-1:0] ovr,
                                                       input logic [SEQ_N-1:0] mode);
    return ovr & ~mode;
  endfunction

  // Sequence flag view selected by the mode bit
  function automatic logic seq_flag_view(input logic mode, input logic dv, input logic sticky);
    return mode ? sticky : dv;
  endfunction
endpackage

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // Set has priority over clear so that no event is dropped
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/adc_seq_flag.sv
module adc_seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic dv_set_i,
  input  logic ovr_set_i,
  input  logic done_i,
  input  logic gdat_rd_i,
  input  logic mode_i,
  input  logic wr_clr_i,
  output logic ovr_o,
  output logic flag_o
);
  import adc_irq_pkg::*;

  logic dv_q;
  logic sticky_q;
  logic sticky_set;

  assign sticky_set = done_i & mode_i;

  adc_flag_bank #(.W(1)) u_dv (
    .clk(clk), .rst_n(rst_n), .set_i(dv_set_i), .clr_i(gdat_rd_i), .q_o(dv_q)
  );

  adc_flag_bank #(.W(1)) u_ovr (
    .clk(clk), .rst_n(rst_n), .set_i(ovr_set_i), .clr_i(gdat_rd_i), .q_o(ovr_o)
  );

  adc_flag_bank #(.W(1)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(sticky_set), .clr_i(wr_clr_i), .q_o(sticky_q)
  );

  assign flag_o = seq_flag_view(mode_i, dv_q, sticky_q);
endmodule

// File: rtl/adc_irq_summary.sv
module adc_irq_summary #(
  parameter int NCH = 12
) (
  input  logic [NCH-1:0]                thr_i,
  input  logic [NCH-1:0]                ch_ovr_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_ovr_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_mode_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_flag_i,
  input  logic [adc_irq_pkg::IRQ_N-1:0] irq_en_i,
  output logic                          thr_sum_o,
  output logic                          ovr_sum_o,
  output logic [adc_irq_pkg::IRQ_N-1:0] irq_o
);
  import adc_irq_pkg::*;

  logic [IRQ_N-1:0] raw;

  assign thr_sum_o = |thr_i;
  assign ovr_sum_o = (|ch_ovr_i) | (|seq_ovr_contrib(seq_ovr_i, seq_mode_i));

  always_comb begin
    raw           = '0;
    raw[IRQ_SEQA] = seq_flag_i[0];
    raw[IRQ_SEQB] = seq_flag_i[1];
    raw[IRQ_THR]  = thr_sum_o;
    raw[IRQ_OVR]  = ovr_sum_o;
  end

  assign irq_o = raw & irq_en_i;
endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags #(
  parameter int NCH = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                thr_evt_i,
  input  logic [NCH-1:0]                ch_ovr_set_i,
  input  logic [NCH-1:0]                ch_rd_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_dv_set_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_ovr_set_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_done_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_gdat_rd_i,
  input  logic [adc_irq_pkg::SEQ_N-1:0] seq_mode_i,
  input  logic                          wr_en_i,
  input  logic [adc_irq_pkg::REG_W-1:0] wr_data_i,
  input  logic [adc_irq_pkg::IRQ_N-1:0] irq_en_i,
  output logic [adc_irq_pkg::REG_W-1:0] rd_data_o,
  output logic [adc_irq_pkg::IRQ_N-1:0] irq_o
);
  import adc_irq_pkg::*;

  localparam int THR_LSB = 0;
  localparam int COV_LSB = NCH;
  localparam int SOV_LSB = 2 * NCH;

  // Named internal events
  logic [NCH-1:0]   thr_clr;
  logic [NCH-1:0]   thr_q;
  logic [NCH-1:0]   cov_q;
  logic [SEQ_N-1:0] seq_wr_clr;
  logic [SEQ_N-1:0] sov_q;
  logic [SEQ_N-1:0] seq_flag;
  logic             thr_sum;
  logic             ovr_sum;

  assign thr_clr = wr_en_i ? wr_data_i[THR_LSB +: NCH] : '0;

  adc_flag_bank #(.W(NCH)) u_thr (
    .clk(clk), .rst_n(rst_n), .set_i(thr_evt_i), .clr_i(thr_clr), .q_o(thr_q)
  );

  adc_flag_bank #(.W(NCH)) u_cov (
    .clk(clk), .rst_n(rst_n), .set_i(ch_ovr_set_i), .clr_i(ch_rd_i), .q_o(cov_q)
  );

  for (genvar s = 0; s < SEQ_N; s++) begin : g_seq
    assign seq_wr_clr[s] = wr_en_i & wr_data_i[SEQ_FLAG_LSB + s];

    adc_seq_flag u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dv_set_i (seq_dv_set_i[s]),
      .ovr_set_i(seq_ovr_set_i[s]),
      .done_i   (seq_done_i[s]),
      .gdat_rd_i(seq_gdat_rd_i[s]),
      .mode_i   (seq_mode_i[s]),
      .wr_clr_i (seq_wr_clr[s]),
      .ovr_o    (sov_q[s]),
      .flag_o   (seq_flag[s])
    );
  end

  adc_irq_summary #(.NCH(NCH)) u_sum (
    .thr_i     (thr_q),
    .ch_ovr_i  (cov_q),
    .seq_ovr_i (sov_q),
    .seq_mode_i(seq_mode_i),
    .seq_flag_i(seq_flag),
    .irq_en_i  (irq_en_i),
    .thr_sum_o (thr_sum),
    .ovr_sum_o (ovr_sum),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data_o                              = '0;
    rd_data_o[THR_LSB +: NCH]              = thr_q;
    rd_data_o[COV_LSB +: NCH]              = cov_q;
    rd_data_o[SOV_LSB +: SEQ_N]            = sov_q;
    rd_data_o[SEQ_FLAG_LSB +: SEQ_N]       = seq_flag;
    rd_data_o[THR_SUM_BIT]                 = thr_sum;
    rd_data_o[OVR_SUM_BIT]                 = ovr_sum;
  end
endmodule

// File: rtl/adc_irq_flags_chk.sv
module adc_irq_flags_chk #(
  parameter int NCH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   thr_evt_i,
  input logic [NCH-1:0]   ch_ovr_set_i,
  input logic [NCH-1:0]   ch_rd_i,
  input logic [1:0]       seq_done_i,
  input logic [1:0]       seq_mode_i,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic [3:0]       irq_en_i,
  input logic [31:0]      rd_data_o,
  input logic [3:0]       irq_o
);
  // R2: every pulsed threshold event is visible one edge later
  a_r2_thr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_evt_i != '0) |=> ((rd_data_o[NCH-1:0] & $past(thr_evt_i)) == $past(thr_evt_i)));

  // R3: write-one clears bits not hit by a concurrent event
  a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((rd_data_o[NCH-1:0] & $past(wr_data_i[NCH-1:0] & ~thr_evt_i)) == '0));

  // R4: channel overrun cleared by its read strobe unless set again
  a_r4_ovr_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd_i != '0) |=> ((rd_data_o[2*NCH-1:NCH] & $past(ch_rd_i & ~ch_ovr_set_i)) == '0));

  // R4: channel overrun set by its pulse
  a_r4_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ovr_set_i != '0) |=> ((rd_data_o[2*NCH-1:NCH] & $past(ch_ovr_set_i)) == $past(ch_ovr_set_i)));

  // R7: completion in end-of-sequence mode raises the sequence flag
  for (genvar s = 0; s < 2; s++) begin : g_seq
    a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode_i[s] && seq_done_i[s]) |=> (rd_data_o[28+s] || !seq_mode_i[s]));
  end

  // R8: threshold summary tracks the threshold flags
  a_r8_thr_sum: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[30] == (rd_data_o[NCH-1:0] != '0));

  // R10: no interrupt line is active without its enable
  a_r10_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~irq_en_i) == 4'b0);

  // R1: reserved bits stay low
  a_r1_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[27:26] == 2'b00);
endmodule

bind adc_irq_flags adc_irq_flags_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr_evt_i   (thr_evt_i),
  .ch_ovr_set_i(ch_ovr_set_i),
  .ch_rd_i     (ch_rd_i),
  .seq_done_i  (seq_done_i),
  .seq_mode_i  (seq_mode_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .irq_en_i    (irq_en_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o)
);

// File: tb/adc_irq_flags_tb.sv
`timescale 1ns/1ps
module adc_irq_flags_tb;
  localparam int NCH = 12;
  localparam int MAXCYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] thr_evt = '0, ch_ovr_set = '0, ch_rd = '0;
  logic [1:0] dv_set = '0, sov_set = '0, done = '0, gdat_rd = '0, mode = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0] irq_en = '0;
  logic [31:0] rd_data;
  logic [3:0] irq;

  always #10 clk = ~clk;

  adc_irq_flags #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .thr_evt_i(thr_evt), .ch_ovr_set_i(ch_ovr_set), .ch_rd_i(ch_rd),
    .seq_dv_set_i(dv_set), .seq_ovr_set_i(sov_set), .seq_done_i(done),
    .seq_gdat_rd_i(gdat_rd), .seq_mode_i(mode),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_en_i(irq_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  bit [NCH-1:0] m_thr, m_cov;
  bit m_sov[2], m_dv[2], m_stk[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr = '0; m_cov = '0;
      for (int s = 0; s < 2; s++) begin m_sov[s] = 0; m_dv[s] = 0; m_stk[s] = 0; end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (thr_evt[i]) m_thr[i] = 1;
        else if (wr_en && wr_data[i]) m_thr[i] = 0;
        if (ch_ovr_set[i]) m_cov[i] = 1;
        else if (ch_rd[i]) m_cov[i] = 0;
      end
      for (int s = 0; s < 2; s++) begin
        if (sov_set[s]) m_sov[s] = 1; else if (gdat_rd[s]) m_sov[s] = 0;
        if (dv_set[s]) m_dv[s] = 1; else if (gdat_rd[s]) m_dv[s] = 0;
        if (mode[s] && done[s]) m_stk[s] = 1;
        else if (wr_en && wr_data[28+s]) m_stk[s] = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every field against the model, tagged by requirement
  task automatic compare_all();
    bit fA, fB, tsum, osum;
    fA = mode[0] ? m_stk[0] : m_dv[0];
    fB = mode[1] ? m_stk[1] : m_dv[1];
    tsum = (m_thr != 0);
    osum = (m_cov != 0) || (m_sov[0] && !mode[0]) || (m_sov[1] && !mode[1]);
    chk("R2/R3 threshold flags", 32'(rd_data[11:0]), 32'(m_thr));
    chk("R4 channel overrun", 32'(rd_data[23:12]), 32'(m_cov));
    chk("R5 sequence overrun", 32'(rd_data[25:24]), {30'b0, m_sov[1], m_sov[0]});
    chk("R1 reserved", 32'(rd_data[27:26]), 32'b0);
    chk(mode[0] ? "R7 seqA flag" : "R6 seqA flag", 32'(rd_data[28]), 32'(fA));
    chk(mode[1] ? "R7 seqB flag" : "R6 seqB flag", 32'(rd_data[29]), 32'(fB));
    chk("R8 threshold summary", 32'(rd_data[30]), 32'(tsum));
    chk("R9 overrun summary", 32'(rd_data[31]), 32'(osum));
    chk("R10 irq gating", 32'(irq), 32'({osum, tsum, fB, fA} & irq_en));
  endtask

  function automatic logic [31:0] rbits(input int pct);
    logic [31:0] v;
    for (int b = 0; b < 32; b++) v[b] = (($urandom % 100) < pct);
    return v;
  endfunction

  task automatic idle();
    thr_evt = '0; ch_ovr_set = '0; ch_rd = '0; dv_set = '0; sov_set = '0;
    done = '0; gdat_rd = '0; wr_en = 0; wr_data = '0;
  endtask

  // One cycle: inputs applied at negedge, outputs compared at following negedge
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  // Random phase with per-group densities
  task automatic phase(input int n, input int p_thr, input int p_ovr, input int p_seq,
                       input int p_wr, input bit mode_rand, input logic [1:0] mode_fix);
    for (int c = 0; c < n; c++) begin
      thr_evt    = rbits(p_thr)[NCH-1:0];
      ch_ovr_set = rbits(p_ovr)[NCH-1:0];
      ch_rd      = rbits(p_ovr)[NCH-1:0];
      dv_set     = rbits(p_seq)[1:0];
      sov_set    = rbits(p_seq)[1:0];
      done       = rbits(p_seq)[1:0];
      gdat_rd    = rbits(p_seq)[1:0];
      wr_en      = (($urandom % 100) < p_wr);
      wr_data    = rbits(50);
      irq_en     = rbits(50)[3:0];
      mode       = mode_rand ? rbits(50)[1:0] : mode_fix;
      step();
    end
    idle();
    step();
  endtask

  initial begin
    #(MAXCYC * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    irq_en = 4'hF;
    #1;
    chk("R1 reset status", rd_data, 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);

    // R3: event and write-one collide on bit 5; write-one alone clears bit 6
    thr_evt = 12'h060; step();
    idle(); thr_evt = 12'h020; wr_en = 1; wr_data = 32'h0000_0060; step();
    idle(); step();
    chk("R3 collision set wins", 32'(rd_data[6:5]), 32'b01);
    // R3: write of zeros keeps bit 5
    wr_en = 1; wr_data = 32'h0; step();
    chk("R3 write zero no effect", 32'(rd_data[5]), 32'b1);
    // R4/R5: writes of ones to read-only bits have no effect
    idle(); ch_ovr_set = 12'h001; sov_set = 2'b01; step();
    idle(); wr_en = 1; wr_data = 32'hC3FF_F000; step();
    chk("R4 R5 read-only bits survive write", 32'(rd_data[25:12]), 32'h1001);
    // R7: sticky flag survives a global-data read in end-of-sequence mode
    idle(); mode = 2'b01; done = 2'b01; step();
    idle(); gdat_rd = 2'b01; step();
    chk("R7 sticky survives read", 32'(rd_data[28]), 32'b1);
    // R9: sequence overrun dropped from summary in end-of-sequence mode
    idle(); ch_rd = '1; step();
    idle(); sov_set = 2'b01; step();
    chk("R9 summary ignores mode-1 seq overrun", 32'(rd_data[31]), 32'b0);
    mode = 2'b00; step();
    chk("R9 summary uses mode-0 seq overrun", 32'(rd_data[31]), 32'b1);

    phase(2000, 20, 0, 0, 30, 0, 2'b00);   // threshold traffic with clears
    phase(2000, 0, 20, 0, 40, 0, 2'b00);   // overruns, reads, stray writes
    phase(2000, 0, 0, 25, 30, 0, 2'b00);   // sequences, per-conversion mode
    phase(2000, 0, 0, 25, 30, 0, 2'b11);   // sequences, end-of-sequence mode
    phase(4000, 15, 15, 20, 30, 1, 2'b00); // everything, toggling modes

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule